// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a video raster, together with the current pixel and line positions. Each axis is described by four programmable lengths (active, front porch, sync, back porch) and a sync polarity. Within a line, and within a frame, the regions follow each other as active, front porch, sync, back porch. The block reports the derived horizontal and vertical totals and the horizontal blanking width. It also raises a flag that allows audio only when the horizontal blanking is long enough to carry it.

Software writes the parameters into a shadow bank and then issues an arm write. The arm write checks the shadow bank. A good set is staged and goes live on the cycle in which the raster wraps back to pixel 0 of line 0. If no raster is running yet, the set goes live on the next cycle. A bad set raises an error flag and is discarded. This allows a reduced-blanking variant of the same active size to replace the running timing without tearing a frame.

Top module: `rasterTimingGen`

## Requirements
- R1: After reset no raster runs: `running`, `de`, `hSync`, `vSync`, `pixX`, `lineY`, all reported totals, `audioOk` and `cfgError` are 0.
- R2: While running, `pixX` counts 0 to hTotal-1 and then wraps to 0. `lineY` advances by one at each wrap and returns to 0 after line vTotal-1.
- R3: `hTotal` and `vTotal` report the sum of active, front porch, sync and back porch of their axis. `hBlank` reports front porch + sync + back porch of the horizontal axis.
- R4: `de` is high exactly when `pixX` is below the horizontal active length and `lineY` is below the vertical active length.
- R5: Sync is asserted on pixels (or lines) from active+front porch up to active+front porch+sync-1. Polarity bit 1 makes that axis active-high and bit 0 makes it active-low. Each axis is selected independently. While not running, both syncs hold their inactive level.
- R6: `audioOk` is 1 when the live horizontal blanking is at least 110 pixels and 0 when it is 109 or less.
- R7: An arm write whose shadow set has a zero active length or a zero sync width on either axis, or a total above 16383, sets `cfgError` and leaves the live timing unchanged. A valid arm clears `cfgError`.
- R8: A staged set goes live only at the edge where the running raster wraps from its last pixel of its last line. Until then the old raster continues unchanged, and after it the counters restart at 0,0 with the new set.
- R9: When no raster is running, a valid arm makes the set live at the next clock edge, and the raster starts at pixel 0, line 0.
- R10: Register map on `wrAddr` with `wrEn`: 0 h-active, 1 h-front porch, 2 h-sync, 3 h-back porch, 4 v-active, 5 v-front porch, 6 v-sync, 7 v-back porch, 8 polarity (bit 0 horizontal, bit 1 vertical), 9 arm. The data is ignored for the arm write.
- R11: Extreme shapes such as 8192 active pixels with 600 lines, or 800 pixels with 7680 lines, are accepted without error. Their totals are reported once they are live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 14 | Register write data |
| hSync | output | 1 | Horizontal sync at programmed polarity |
| vSync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable (active area) |
| pixX | output | 14 | Current pixel within the line |
| lineY | output | 14 | Current line within the frame |
| hTotal | output | 14 | Live horizontal total |
| vTotal | output | 14 | Live vertical total |
| hBlank | output | 14 | Live horizontal blanking width |
| audioOk | output | 1 | Audio permitted by blanking length |
| cfgError | output | 1 | Last arm was rejected |
| running | output | 1 | A valid set is live and the raster runs |

## Verification
On every cycle the assertions check that the counters stay below the live totals and step by one pixel or line between wraps. They also check that data-enable never leaves the live active area, that a commit always restarts the raster at the origin, and that totals and audio permission change only on a commit. The exact placement and polarity of each sync pulse, the rejection of bad sets, and the timing of a frame-boundary swap can be seen only in the bench scenarios. There a cycle-by-cycle model of the raster is run across several shapes and is compared with every output.

// File: rtl/rasterPkg.sv
package rasterPkg;
  localparam int CNT_W = 14;
  localparam int SUM_W = CNT_W + 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SUM_W-1:0] sum_t;

  typedef struct packed {
    cnt_t hAct;
    cnt_t hFp;
    cnt_t hSw;
    cnt_t hBp;
    cnt_t vAct;
    cnt_t vFp;
    cnt_t vSw;
    cnt_t vBp;
    logic hPol;
    logic vPol;
  } timing_t;

  typedef struct packed {
    logic commit;
    logic run;
  } strobes_t;

  localparam timing_t IDLE_CFG = '{hPol: 1'b1, vPol: 1'b1, default: '0};
endpackage

// File: rtl/rasterCtrl.sv
module rasterCtrl
  import rasterPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AUDIO_MIN_BLANK = 110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  cnt_t              wrData,
  input  logic              frameEnd,
  output strobes_t          strobes,
  output timing_t           work,
  output cnt_t              hTotal,
  output cnt_t              vTotal,
  output cnt_t              hBlank,
  output logic              audioOk,
  output logic              cfgError
);
  localparam logic [ADDR_W-1:0] A_HACT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HFP  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HSW  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HBP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VACT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VFP  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_VSW  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_VBP  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(9);
  localparam sum_t MAX_TOTAL = sum_t'((1 << CNT_W) - 1);

  timing_t shadow, staged;
  cnt_t    stHTot, stVTot, stHBlank;
  logic    pending, workValid;
  sum_t    shHBlank, shHTot, shVTot;
  logic    shapeOk, armReq, commit;

  // Sums are formed once, on the shadow bank, and staged with the set.
  always_comb begin
    shHBlank = sum_t'(shadow.hFp) + sum_t'(shadow.hSw) + sum_t'(shadow.hBp);
    shHTot   = shHBlank + sum_t'(shadow.hAct);
    shVTot   = sum_t'(shadow.vAct) + sum_t'(shadow.vFp) + sum_t'(shadow.vSw) + sum_t'(shadow.vBp);
    shapeOk  = (shadow.hAct != '0) && (shadow.vAct != '0) &&
               (shadow.hSw != '0) && (shadow.vSw != '0) &&
               (shHTot <= MAX_TOTAL) && (shVTot <= MAX_TOTAL);
    armReq   = wrEn && (wrAddr == A_ARM);
    commit   = pending && (!workValid || frameEnd);
  end

  assign strobes.commit = commit;
  assign strobes.run    = workValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow    <= IDLE_CFG;
      staged    <= IDLE_CFG;
      work      <= IDLE_CFG;
      stHTot    <= '0;
      stVTot    <= '0;
      stHBlank  <= '0;
      hTotal    <= '0;
      vTotal    <= '0;
      hBlank    <= '0;
      audioOk   <= 1'b0;
      cfgError  <= 1'b0;
      pending   <= 1'b0;
      workValid <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          A_HACT: shadow.hAct <= wrData;
          A_HFP:  shadow.hFp  <= wrData;
          A_HSW:  shadow.hSw  <= wrData;
          A_HBP:  shadow.hBp  <= wrData;
          A_VACT: shadow.vAct <= wrData;
          A_VFP:  shadow.vFp  <= wrData;
          A_VSW:  shadow.vSw  <= wrData;
          A_VBP:  shadow.vBp  <= wrData;
          A_POL: begin
            shadow.hPol <= wrData[0];
            shadow.vPol <= wrData[1];
          end
          default: ;
        endcase
      end
      if (commit) begin
        work      <= staged;
        hTotal    <= stHTot;
        vTotal    <= stVTot;
        hBlank    <= stHBlank;
        audioOk   <= (stHBlank >= cnt_t'(AUDIO_MIN_BLANK));
        workValid <= 1'b1;
        pending   <= 1'b0;
      end
      if (armReq) begin
        if (shapeOk) begin
          staged   <= shadow;
          stHTot   <= cnt_t'(shHTot);
          stVTot   <= cnt_t'(shVTot);
          stHBlank <= cnt_t'(shHBlank);
          pending  <= 1'b1;
          cfgError <= 1'b0;
        end else begin
          cfgError <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rasterAxis.sv
module rasterAxis
  import rasterPkg::*;
(
  input  logic run,
  input  cnt_t pos,
  input  cnt_t act,
  input  cnt_t fp,
  input  cnt_t sw,
  input  logic pol,
  output logic inActive,
  output logic syncLevel
);
  sum_t syncStart, syncEnd;
  logic inSync;

  always_comb begin
    syncStart = sum_t'(act) + sum_t'(fp);
    syncEnd   = syncStart + sum_t'(sw);
    inSync    = (sum_t'(pos) >= syncStart) && (sum_t'(pos) < syncEnd);
    inActive  = pos < act;
    syncLevel = run ? (inSync ~^ pol) : ~pol;
  end
endmodule

// File: rtl/rasterDatapath.sv
module rasterDatapath
  import rasterPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  timing_t  work,
  input  cnt_t     hTotal,
  input  cnt_t     vTotal,
  output cnt_t     pixX,
  output cnt_t     lineY,
  output logic     hSync,
  output logic     vSync,
  output logic     de,
  output logic     frameEnd
);
  localparam int AXES = 2;

  logic hLast, vLast;
  cnt_t axPos [AXES];
  cnt_t axAct [AXES];
  cnt_t axFp  [AXES];
  cnt_t axSw  [AXES];
  logic axPol [AXES];
  logic axActive [AXES];
  logic axSync   [AXES];

  assign hLast    = (pixX == hTotal - cnt_t'(1));
  assign vLast    = (lineY == vTotal - cnt_t'(1));
  assign frameEnd = strobes.run && hLast && vLast;

  assign axPos[0] = pixX;      assign axPos[1] = lineY;
  assign axAct[0] = work.hAct; assign axAct[1] = work.vAct;
  assign axFp[0]  = work.hFp;  assign axFp[1]  = work.vFp;
  assign axSw[0]  = work.hSw;  assign axSw[1]  = work.vSw;
  assign axPol[0] = work.hPol; assign axPol[1] = work.vPol;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    rasterAxis u_axis (
      .run      (strobes.run),
      .pos      (axPos[a]),
      .act      (axAct[a]),
      .fp       (axFp[a]),
      .sw       (axSw[a]),
      .pol      (axPol[a]),
      .inActive (axActive[a]),
      .syncLevel(axSync[a])
    );
  end

  assign hSync = axSync[0];
  assign vSync = axSync[1];
  assign de    = strobes.run && axActive[0] && axActive[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixX  <= '0;
      lineY <= '0;
    end else if (strobes.commit) begin
      pixX  <= '0;
      lineY <= '0;
    end else if (strobes.run) begin
      if (hLast) begin
        pixX  <= '0;
        lineY <= vLast ? '0 : lineY + cnt_t'(1);
      end else begin
        pixX <= pixX + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/rasterTimingGen.sv
module rasterTimingGen
  import rasterPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AUDIO_MIN_BLANK = 110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              hSync,
  output logic              vSync,
  output logic              de,
  output logic [CNT_W-1:0]  pixX,
  output logic [CNT_W-1:0]  lineY,
  output logic [CNT_W-1:0]  hTotal,
  output logic [CNT_W-1:0]  vTotal,
  output logic [CNT_W-1:0]  hBlank,
  output logic              audioOk,
  output logic              cfgError,
  output logic              running
);
  strobes_t strobes;
  timing_t  work;
  logic     frameEnd;

  rasterCtrl #(.ADDR_W(ADDR_W), .AUDIO_MIN_BLANK(AUDIO_MIN_BLANK)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .frameEnd(frameEnd),
    .strobes (strobes),
    .work    (work),
    .hTotal  (hTotal),
    .vTotal  (vTotal),
    .hBlank  (hBlank),
    .audioOk (audioOk),
    .cfgError(cfgError)
  );

  rasterDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .work    (work),
    .hTotal  (hTotal),
    .vTotal  (vTotal),
    .pixX    (pixX),
    .lineY   (lineY),
    .hSync   (hSync),
    .vSync   (vSync),
    .de      (de),
    .frameEnd(frameEnd)
  );

  assign running = strobes.run;
endmodule

// File: rtl/rasterChecker.sv
module rasterChecker
  import rasterPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     running,
  input logic     de,
  input cnt_t     pixX,
  input cnt_t     lineY,
  input cnt_t     hTotal,
  input cnt_t     vTotal,
  input logic     audioOk,
  input strobes_t strobes,
  input timing_t  work
);
  p_x_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (pixX < hTotal));

  p_y_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (lineY < vTotal));

  p_pix_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobes.commit && pixX != hTotal - cnt_t'(1))
      |=> (pixX == $past(pixX) + cnt_t'(1)));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobes.commit && pixX == hTotal - cnt_t'(1) && lineY != vTotal - cnt_t'(1))
      |=> (pixX == '0 && lineY == $past(lineY) + cnt_t'(1)));

  p_de_area_r4: assert property (@(posedge clk) disable iff (!rstN)
    de |-> (pixX < work.hAct && lineY < work.vAct));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !de);

  p_commit_origin_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (running && pixX == '0 && lineY == '0));

  p_totals_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(hTotal) && $stable(vTotal)));

  p_audio_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(audioOk));
endmodule

bind rasterTimingGen rasterChecker u_rasterChecker (.*);

// File: tb/tb_rasterTimingGen.sv
module tb_rasterTimingGen;
  typedef int cfg_t[10];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [13:0] wrData = '0;
  logic        hSync, vSync, de, audioOk, cfgError, running;
  logic [13:0] pixX, lineY, hTotal, vTotal, hBlank;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  cfg_t sh, st, wk;
  int ex, ey;
  bit mRun, mPend, mErr;

  always #5 clk = ~clk;

  rasterTimingGen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSync(hSync), .vSync(vSync), .de(de), .pixX(pixX), .lineY(lineY),
    .hTotal(hTotal), .vTotal(vTotal), .hBlank(hBlank), .audioOk(audioOk),
    .cfgError(cfgError), .running(running)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (x=%0d y=%0d t=%0t)", req, what, act, exp, ex, ey, $time);
    end
  endtask

  function automatic cfg_t idleCfg();
    cfg_t c;
    for (int i = 0; i < 10; i++) c[i] = 0;
    c[8] = 1; c[9] = 1;
    return c;
  endfunction

  // Expected behaviour at one clock edge, derived from R2, R7, R8, R9, R10.
  task automatic modelEdge(input bit we, input int addr, input int data);
    int hT, vT, hS, vS;
    bit fe, cm;
    hT = wk[0] + wk[1] + wk[2] + wk[3];
    vT = wk[4] + wk[5] + wk[6] + wk[7];
    fe = mRun && ex == hT - 1 && ey == vT - 1;
    cm = mPend && (!mRun || fe);
    if (cm) begin
      ex = 0; ey = 0;
    end else if (mRun) begin
      if (ex == hT - 1) begin
        ex = 0;
        ey = (ey == vT - 1) ? 0 : ey + 1;
      end else ex++;
    end
    if (cm) begin
      wk = st; mRun = 1; mPend = 0;
    end
    if (we) begin
      if (addr < 8) sh[addr] = data;
      else if (addr == 8) begin
        sh[8] = data & 1; sh[9] = (data >> 1) & 1;
      end else if (addr == 9) begin
        hS = sh[0] + sh[1] + sh[2] + sh[3];
        vS = sh[4] + sh[5] + sh[6] + sh[7];
        if (sh[0] != 0 && sh[4] != 0 && sh[2] != 0 && sh[6] != 0 && hS <= 16383 && vS <= 16383) begin
          st = sh; mPend = 1; mErr = 0;
        end else mErr = 1;
      end
    end
  endtask

  task automatic compareAll();
    int hB, hs0, hs1, vs0, vs1;
    bit eHs, eVs, eDe;
    hB = wk[1] + wk[2] + wk[3];
    hs0 = wk[0] + wk[1]; hs1 = hs0 + wk[2];
    vs0 = wk[4] + wk[5]; vs1 = vs0 + wk[6];
    eHs = mRun ? ((ex >= hs0 && ex < hs1) ? wk[8][0] : !wk[8][0]) : !wk[8][0];
    eVs = mRun ? ((ey >= vs0 && ey < vs1) ? wk[9][0] : !wk[9][0]) : !wk[9][0];
    eDe = mRun && ex < wk[0] && ey < wk[4];
    chk("R2", "pixX", int'(pixX), ex);
    chk("R2", "lineY", int'(lineY), ey);
    chk("R4", "de", int'(de), int'(eDe));
    chk("R5", "hSync", int'(hSync), int'(eHs));
    chk("R5", "vSync", int'(vSync), int'(eVs));
    chk("R3", "hTotal", int'(hTotal), wk[0] + wk[1] + wk[2] + wk[3]);
    chk("R3", "vTotal", int'(vTotal), wk[4] + wk[5] + wk[6] + wk[7]);
    chk("R3", "hBlank", int'(hBlank), hB);
    chk("R6", "audioOk", int'(audioOk), int'(hB >= 110));
    chk("R7", "cfgError", int'(cfgError), int'(mErr));
    chk("R9", "running", int'(running), int'(mRun));
  endtask

  task automatic step(input bit we, input int addr, input int data);
    wrEn = we; wrAddr = 4'(addr); wrData = 14'(data);
    @(posedge clk);
    modelEdge(we, addr, data);
    @(negedge clk);
    wrEn = 1'b0;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // R10: fields at addresses 0..7, polarity at 8, arm at 9.
  task automatic loadAndArm(input int ha, hf, hw, hb, va, vf, vw, vb, pol);
    step(1, 0, ha); step(1, 1, hf); step(1, 2, hw); step(1, 3, hb);
    step(1, 4, va); step(1, 5, vf); step(1, 6, vw); step(1, 7, vb);
    step(1, 8, pol); step(1, 9, 0);
  endtask

  initial begin
    sh = idleCfg(); st = idleCfg(); wk = idleCfg();
    ex = 0; ey = 0; mRun = 0; mPend = 0; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle state after reset
    compareAll();
    idle(4);
    // R7: arm with an all-zero shadow is rejected
    step(1, 9, 0);
    idle(3);
    // R9: first valid set starts from idle; R2 R4 R5 sweep, both active-high
    loadAndArm(4, 2, 3, 1, 3, 1, 2, 1, 3);
    idle(140);
    // R8: reduced-blanking swap armed mid-frame, h active-high, v active-low
    loadAndArm(4, 1, 1, 2, 3, 1, 1, 1, 1);
    idle(200);
    // R7: zero horizontal sync rejected, raster unchanged
    step(1, 2, 0); step(1, 9, 0);
    idle(60);
    // R6: blanking exactly 110 allows audio
    loadAndArm(4, 50, 10, 50, 2, 1, 1, 1, 2);
    idle(1200);
    // R6: blanking 109 forbids audio
    loadAndArm(4, 50, 10, 49, 2, 1, 1, 1, 0);
    idle(1200);
    // R7: horizontal total above 16383 rejected
    loadAndArm(16000, 200, 100, 100, 2, 1, 1, 1, 3);
    idle(20);
    // R11: 8192 x 600 accepted, goes live, crosses a line wrap
    loadAndArm(8192, 8, 32, 40, 600, 3, 5, 6, 3);
    idle(9000);
    // R11: 800 x 7680 accepted without error (staged)
    loadAndArm(800, 48, 32, 80, 7680, 3, 6, 20, 0);
    idle(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule